// File: doc/BRIEF.md
# Codec Register Access Engine

This block is a bus master for the narrow register port of an on-chip audio codec. A host hands it one request at a time: a read, a write or a masked update. Each request carries a register address, a data byte, a mask byte, an index and a flag that picks direct or indirect decoding. The engine breaks each request into single bus accesses, runs them in order and reports the outcome with a one-cycle `done` pulse.

A direct register sits at the given address. An indirect register is reached through a pair of registers. The control register sits at the given address A and the data register at A+1, where the address wraps. The engine first rewrites the control register with the index and a write-enable bit, and only then touches the data register. Reads are sampled a fixed number of cycles after the address is presented. Writes raise a strobe that stays up until the codec acknowledges it. If no acknowledge arrives within a bounded number of cycles, the strobe is withdrawn and the request ends with an error.

Top module: `codec_reg_engine`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy`, `done`, `bus_wr` and `rsp_err` are 0.
- R2: The request code `req_op` is 0 for read, 1 for write, 2 for update. A direct read (`req_indirect`=0) returns the byte at `req_addr` on `rsp_data`, raises no write strobe and leaves every register unchanged.
- R3: A direct write stores `req_data` at `req_addr`. While `bus_wr` is high, `bus_addr` and `bus_wdata` stay stable. `bus_wr` falls in the cycle after `bus_wr_ack` is seen high.
- R4: A direct update reads the register and writes back (old & ~`req_mask`) | `req_data`, which is also returned on `rsp_data`. It makes exactly one write.
- R5: An indirect write with control address A makes two writes in this order. First the control register at A gets {old bit 7, 1 in bit 6, index in bits 5:0}. Then the data register at A+1 gets `req_data`.
- R6: An indirect read writes the control register at A once, as {old bit 7, 0 in bit 6, index in bits 5:0}. It then returns the byte at A+1.
- R7: An indirect update performs an indirect read of A+1 and then an indirect write of (old & ~mask) | data. The control register ends with bit 6 set. The request makes three writes, the last one to A+1.
- R8: Only bits 5:0 of `req_index` reach the control register. Bits 7:6 of the index have no effect.
- R9: Request code 3 is reserved. It completes with `done` and `rsp_err`=1 in the cycle after acceptance, with no bus write.
- R10: A request is accepted when `req_valid` is high and `busy` is low. `busy` stays high from the next cycle until the cycle in which `done` pulses. Requests offered while busy are dropped, and no write strobe is raised while idle.
- R11: A write that is not acknowledged within `TIMEOUT_CYC` strobe cycles is abandoned: `bus_wr` falls, the remaining accesses are skipped, and the request ends with `rsp_err`=1.
- R12: For indirect access with A equal to the highest address, the data register is at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered this cycle |
| req_op | input | 2 | 0 read, 1 write, 2 update, 3 reserved |
| req_indirect | input | 1 | 1 selects indirect decoding |
| req_addr | input | AW | Direct address, or control address for indirect |
| req_index | input | DW | Indirect index, low IDXW bits used |
| req_data | input | DW | Write value or update value |
| req_mask | input | DW | Update mask, 1 clears the bit |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_data | output | DW | Read value or written target value |
| rsp_err | output | 1 | Request failed (timeout or reserved code) |
| bus_addr | output | AW | Codec register address |
| bus_wdata | output | DW | Codec write data |
| bus_wr | output | 1 | Write strobe, held until acknowledged |
| bus_wr_ack | input | 1 | Codec clears the write strobe |
| bus_rdata | input | DW | Codec read data for `bus_addr` |

## Verification
The bench builds the engine with 8-bit address and data, a 6-bit index, a read wait of 2 cycles and a write timeout of only 12 cycles. The short timeout lets a stalled codec model push the engine into abort within a few dozen cycles, both on a direct write and on the control write of an indirect sequence. The bench's codec model acknowledges writes after a random delay of 0 to 3 cycles. As a result, the strobe-hold and acknowledge paths are crossed at several distances, and the control-before-data order is seen under varied timing, including the address wrap at the top of the map.

// File: rtl/codec_reg_pkg.sv
package codec_reg_pkg;

  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_WRITE  = 2'd1,
    OP_UPDATE = 2'd2,
    OP_RSVD   = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_RD   = 2'd1,
    ACC_WR   = 2'd2
  } acc_e;

  // where the value of a write access comes from
  typedef enum logic [1:0] {
    VAL_REQ    = 2'd0,  // request data as given
    VAL_MERGE  = 2'd1,  // (target read & ~mask) | data
    VAL_SEL_RD = 2'd2,  // control word, write-enable clear
    VAL_SEL_WR = 2'd3   // control word, write-enable set
  } vsrc_e;

  typedef struct packed {
    acc_e  acc;
    logic  tgt;   // 1: target register (direct, or data reg of a pair)
    vsrc_e src;
    logic  last;
  } step_t;

  localparam int STEP_W = 3;

endpackage

// File: rtl/codec_reg_planner.sv
module codec_reg_planner
  import codec_reg_pkg::*;
(
  input  op_e               op,
  input  logic              ind,
  input  logic [STEP_W-1:0] idx,
  output step_t             step
);

  function automatic step_t mk(acc_e a, logic t, vsrc_e s, logic l);
    step_t r;
    r.acc  = a;
    r.tgt  = t;
    r.src  = s;
    r.last = l;
    return r;
  endfunction

  always_comb begin
    step = mk(ACC_NONE, 1'b0, VAL_REQ, 1'b1);
    if (!ind) begin
      unique case (op)
        OP_READ:   if (idx == 3'd0) step = mk(ACC_RD, 1'b1, VAL_REQ, 1'b1);
        OP_WRITE:  if (idx == 3'd0) step = mk(ACC_WR, 1'b1, VAL_REQ, 1'b1);
        OP_UPDATE: begin
          if (idx == 3'd0) step = mk(ACC_RD, 1'b1, VAL_REQ,   1'b0);
          if (idx == 3'd1) step = mk(ACC_WR, 1'b1, VAL_MERGE, 1'b1);
        end
        default: ;
      endcase
    end else begin
      unique case (op)
        OP_READ: begin
          if (idx == 3'd0) step = mk(ACC_RD, 1'b0, VAL_REQ,    1'b0);
          if (idx == 3'd1) step = mk(ACC_WR, 1'b0, VAL_SEL_RD, 1'b0);
          if (idx == 3'd2) step = mk(ACC_RD, 1'b1, VAL_REQ,    1'b1);
        end
        OP_WRITE: begin
          if (idx == 3'd0) step = mk(ACC_RD, 1'b0, VAL_REQ,    1'b0);
          if (idx == 3'd1) step = mk(ACC_WR, 1'b0, VAL_SEL_WR, 1'b0);
          if (idx == 3'd2) step = mk(ACC_WR, 1'b1, VAL_REQ,    1'b1);
        end
        OP_UPDATE: begin
          // indirect read of the data register, then indirect write back
          if (idx == 3'd0) step = mk(ACC_RD, 1'b0, VAL_REQ,    1'b0);
          if (idx == 3'd1) step = mk(ACC_WR, 1'b0, VAL_SEL_RD, 1'b0);
          if (idx == 3'd2) step = mk(ACC_RD, 1'b1, VAL_REQ,    1'b0);
          if (idx == 3'd3) step = mk(ACC_RD, 1'b0, VAL_REQ,    1'b0);
          if (idx == 3'd4) step = mk(ACC_WR, 1'b0, VAL_SEL_WR, 1'b0);
          if (idx == 3'd5) step = mk(ACC_WR, 1'b1, VAL_MERGE,  1'b1);
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/codec_reg_wval.sv
module codec_reg_wval
  import codec_reg_pkg::*;
#(
  parameter int DW   = 8,
  parameter int IDXW = 6
) (
  input  vsrc_e         src,
  input  logic [DW-1:0] req_data,
  input  logic [DW-1:0] req_mask,
  input  logic [DW-1:0] req_index,
  input  logic [DW-1:0] val_q,
  input  logic [DW-1:0] ctl_q,
  output logic [DW-1:0] wval
);

  localparam logic [DW-1:0] LOW_MASK = DW'((1 << (IDXW + 1)) - 1);
  localparam logic [DW-1:0] IDX_MASK = DW'((1 << IDXW) - 1);
  localparam logic [DW-1:0] WE_BIT   = DW'(1 << IDXW);

  logic [DW-1:0] sel_base;

  always_comb begin
    sel_base = (ctl_q & ~LOW_MASK) | (req_index & IDX_MASK);
    unique case (src)
      VAL_MERGE:  wval = (val_q & ~req_mask) | req_data;
      VAL_SEL_RD: wval = sel_base;
      VAL_SEL_WR: wval = sel_base | WE_BIT;
      default:    wval = req_data;
    endcase
  end

endmodule

// File: rtl/codec_reg_busport.sv
module codec_reg_busport
  import codec_reg_pkg::*;
#(
  parameter int AW          = 8,
  parameter int DW          = 8,
  parameter int RD_WAIT_CYC = 1,
  parameter int TIMEOUT_CYC = 1024
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  acc_e          acc,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          acc_done,
  output logic          acc_tmo,
  output logic [DW-1:0] acc_rdata,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_wr,
  input  logic          bus_wr_ack,
  input  logic [DW-1:0] bus_rdata
);

  localparam int RW_W = $clog2(RD_WAIT_CYC + 1);
  localparam int TO_W = $clog2(TIMEOUT_CYC + 1);

  typedef enum logic [1:0] {P_IDLE, P_RD, P_WR} pst_e;

  pst_e          st;
  logic [RW_W-1:0] rcnt;
  logic [TO_W-1:0] tcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= P_IDLE;
      rcnt      <= '0;
      tcnt      <= '0;
      acc_done  <= 1'b0;
      acc_tmo   <= 1'b0;
      acc_rdata <= '0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      bus_wr    <= 1'b0;
    end else begin
      acc_done <= 1'b0;
      acc_tmo  <= 1'b0;
      unique case (st)
        P_IDLE: begin
          if (start && acc == ACC_WR) begin
            bus_addr  <= addr;
            bus_wdata <= wdata;
            bus_wr    <= 1'b1;
            tcnt      <= '0;
            st        <= P_WR;
          end else if (start && acc == ACC_RD) begin
            bus_addr <= addr;
            rcnt     <= RW_W'(1);
            st       <= P_RD;
          end
        end
        P_RD: begin
          if (rcnt == RW_W'(RD_WAIT_CYC)) begin
            acc_rdata <= bus_rdata;
            acc_done  <= 1'b1;
            st        <= P_IDLE;
          end else begin
            rcnt <= rcnt + 1'b1;
          end
        end
        P_WR: begin
          if (bus_wr_ack) begin
            bus_wr   <= 1'b0;
            acc_done <= 1'b1;
            st       <= P_IDLE;
          end else if (tcnt == TO_W'(TIMEOUT_CYC - 1)) begin
            bus_wr   <= 1'b0;
            acc_done <= 1'b1;
            acc_tmo  <= 1'b1;
            st       <= P_IDLE;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        default: st <= P_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/codec_reg_engine.sv
module codec_reg_engine
  import codec_reg_pkg::*;
#(
  parameter int AW          = 8,
  parameter int DW          = 8,
  parameter int IDXW        = 6,
  parameter int RD_WAIT_CYC = 1,
  parameter int TIMEOUT_CYC = 1024
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic          req_indirect,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_index,
  input  logic [DW-1:0] req_data,
  input  logic [DW-1:0] req_mask,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_err,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_wr,
  input  logic          bus_wr_ack,
  input  logic [DW-1:0] bus_rdata
);

  typedef enum logic [1:0] {T_IDLE, T_ISSUE, T_WAIT} tst_e;

  tst_e              st;
  op_e               op_q;
  logic              ind_q;
  logic [AW-1:0]     addr_q;
  logic [DW-1:0]     idx_q, data_q, mask_q;
  logic [DW-1:0]     val_q, ctl_q;
  logic [STEP_W-1:0] step_q;

  step_t         cur;
  logic [AW-1:0] acc_addr;
  logic [DW-1:0] wval;
  logic          acc_done, acc_tmo;
  logic [DW-1:0] acc_rdata;

  codec_reg_planner u_plan (
    .op   (op_q),
    .ind  (ind_q),
    .idx  (step_q),
    .step (cur)
  );

  codec_reg_wval #(.DW(DW), .IDXW(IDXW)) u_wval (
    .src       (cur.src),
    .req_data  (data_q),
    .req_mask  (mask_q),
    .req_index (idx_q),
    .val_q     (val_q),
    .ctl_q     (ctl_q),
    .wval      (wval)
  );

  assign acc_addr = (ind_q && cur.tgt) ? AW'(addr_q + 1'b1) : addr_q;

  codec_reg_busport #(
    .AW(AW), .DW(DW), .RD_WAIT_CYC(RD_WAIT_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_port (
    .clk        (clk),
    .rst        (rst),
    .start      (st == T_ISSUE),
    .acc        (cur.acc),
    .addr       (acc_addr),
    .wdata      (wval),
    .acc_done   (acc_done),
    .acc_tmo    (acc_tmo),
    .acc_rdata  (acc_rdata),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_wr     (bus_wr),
    .bus_wr_ack (bus_wr_ack),
    .bus_rdata  (bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= T_IDLE;
      op_q     <= OP_READ;
      ind_q    <= 1'b0;
      addr_q   <= '0;
      idx_q    <= '0;
      data_q   <= '0;
      mask_q   <= '0;
      val_q    <= '0;
      ctl_q    <= '0;
      step_q   <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      rsp_data <= '0;
      rsp_err  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        T_IDLE: begin
          if (req_valid) begin
            op_q    <= op_e'(req_op);
            ind_q   <= req_indirect;
            addr_q  <= req_addr;
            idx_q   <= req_index;
            data_q  <= req_data;
            mask_q  <= req_mask;
            step_q  <= '0;
            rsp_err <= 1'b0;
            if (op_e'(req_op) == OP_RSVD) begin
              done    <= 1'b1;
              rsp_err <= 1'b1;
            end else begin
              busy <= 1'b1;
              st   <= T_ISSUE;
            end
          end
        end
        T_ISSUE: begin
          if (cur.acc == ACC_NONE) begin
            busy    <= 1'b0;
            done    <= 1'b1;
            rsp_err <= 1'b1;
            st      <= T_IDLE;
          end else begin
            if (cur.acc == ACC_WR && cur.tgt) val_q <= wval;
            st <= T_WAIT;
          end
        end
        T_WAIT: begin
          if (acc_done) begin
            if (acc_tmo) begin
              busy    <= 1'b0;
              done    <= 1'b1;
              rsp_err <= 1'b1;
              st      <= T_IDLE;
            end else begin
              if (cur.acc == ACC_RD) begin
                if (cur.tgt) val_q <= acc_rdata;
                else         ctl_q <= acc_rdata;
              end
              if (cur.last) begin
                rsp_data <= (cur.acc == ACC_RD) ? acc_rdata : val_q;
                busy     <= 1'b0;
                done     <= 1'b1;
                st       <= T_IDLE;
              end else begin
                step_q <= step_q + 1'b1;
                st     <= T_ISSUE;
              end
            end
          end
        end
        default: st <= T_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/codec_reg_sva.sv
module codec_reg_sva #(
  parameter int TIMEOUT_CYC = 1024
) (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic rsp_err,
  input logic bus_wr,
  input logic bus_wr_ack,
  input logic [7:0] bus_addr_lo,
  input logic [7:0] bus_wdata_lo
);

  localparam int RUN_W = $clog2(TIMEOUT_CYC + 2);
  logic [RUN_W-1:0] wr_run;

  always_ff @(posedge clk) begin
    if (rst)          wr_run <= '0;
    else if (bus_wr)  wr_run <= wr_run + 1'b1;
    else              wr_run <= '0;
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!busy && !done && !bus_wr && !rsp_err)); // R1

  AST_WR_HELD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && $past(bus_wr)) |-> ($stable(bus_addr_lo) && $stable(bus_wdata_lo))); // R3

  AST_ACK_DROPS_STROBE: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_wr_ack) |=> !bus_wr); // R3

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R10

  AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done); // R10

  AST_NO_WR_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !bus_wr); // R10

  AST_WR_TIMEOUT_BOUND: assert property (@(posedge clk) disable iff (rst)
    wr_run <= RUN_W'(TIMEOUT_CYC)); // R11

endmodule

bind codec_reg_engine codec_reg_sva #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_sva (
  .clk          (clk),
  .rst          (rst),
  .busy         (busy),
  .done         (done),
  .rsp_err      (rsp_err),
  .bus_wr       (bus_wr),
  .bus_wr_ack   (bus_wr_ack),
  .bus_addr_lo  (8'(bus_addr)),
  .bus_wdata_lo (8'(bus_wdata))
);

// File: tb/tb_codec_reg_engine.sv
module tb_codec_reg_engine;

  localparam int AW  = 8;
  localparam int DW  = 8;
  localparam int RDW = 2;
  localparam int TMO = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [1:0]    req_op = 2'd0;
  logic          req_indirect = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_index = '0, req_data = '0, req_mask = '0;
  logic          busy, done, rsp_err, bus_wr;
  logic          bus_wr_ack;
  logic [DW-1:0] rsp_data, bus_wdata, bus_rdata;
  logic [AW-1:0] bus_addr;

  always #4 clk = ~clk;

  codec_reg_engine #(
    .AW(AW), .DW(DW), .IDXW(6), .RD_WAIT_CYC(RDW), .TIMEOUT_CYC(TMO)
  ) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_indirect(req_indirect), .req_addr(req_addr), .req_index(req_index),
    .req_data(req_data), .req_mask(req_mask), .busy(busy), .done(done),
    .rsp_data(rsp_data), .rsp_err(rsp_err), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_wr_ack(bus_wr_ack),
    .bus_rdata(bus_rdata)
  );

  // codec register file model
  logic [7:0]  cmem [256];
  logic [7:0]  shadow [256];
  logic        stall = 1'b0;
  int unsigned ack_dly = 0;
  int unsigned ack_cnt;
  int          wr_count;
  logic [7:0]  last_wr_addr, prev_wr_addr;

  assign bus_rdata = cmem[bus_addr];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) cmem[i] <= 8'(i * 37 + 5);
      bus_wr_ack   <= 1'b0;
      ack_cnt      <= 0;
      wr_count     <= 0;
      last_wr_addr <= '0;
      prev_wr_addr <= '0;
    end else begin
      bus_wr_ack <= 1'b0;
      if (bus_wr && !bus_wr_ack && !stall) begin
        if (ack_cnt >= ack_dly) begin
          bus_wr_ack     <= 1'b1;
          cmem[bus_addr] <= bus_wdata;
          ack_cnt        <= 0;
          wr_count       <= wr_count + 1;
          prev_wr_addr   <= last_wr_addr;
          last_wr_addr   <= bus_addr;
        end else begin
          ack_cnt <= ack_cnt + 1;
        end
      end
    end
  end

  int checks = 0;
  int fails  = 0;
  int total_cyc = 0;

  always @(posedge clk) begin
    total_cyc++;
    if (total_cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", total_cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send(int op, bit ind, int a, int idx, int d, int m);
    @(negedge clk);
    req_op = 2'(op); req_indirect = ind; req_addr = 8'(a);
    req_index = 8'(idx); req_data = 8'(d); req_mask = 8'(m);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(string req, output int cyc);
    cyc = 0;
    while (!done && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
    if (!done) chk(req, "done timeout", 0, 1);
  endtask

  // reference model on the shadow map
  task automatic ref_apply(int op, bit ind, int a, int idx, int d, int m,
                           output int rsp, output int w, output int last, output int prev);
    logic [7:0] b, i6, v, aa, dd, mm;
    aa = 8'(a); dd = 8'(d); mm = 8'(m);
    b = aa + 8'd1; i6 = 8'(idx) & 8'h3F;
    rsp = 0; w = 0; last = 0; prev = 0;
    if (!ind) begin
      if (op == 0) begin rsp = shadow[aa]; end
      else if (op == 1) begin shadow[aa] = dd; rsp = dd; w = 1; last = aa; end
      else begin v = (shadow[aa] & ~mm) | dd; shadow[aa] = v; rsp = v; w = 1; last = aa; end
    end else begin
      if (op == 0) begin
        shadow[aa] = (shadow[aa] & 8'h80) | i6; rsp = shadow[b]; w = 1; last = aa;
      end else if (op == 1) begin
        shadow[aa] = (shadow[aa] & 8'h80) | 8'h40 | i6; shadow[b] = dd;
        rsp = dd; w = 2; prev = aa; last = b;
      end else begin
        shadow[aa] = (shadow[aa] & 8'h80) | i6;
        v = (shadow[b] & ~mm) | dd;
        shadow[aa] = shadow[aa] | 8'h40;
        shadow[b] = v; rsp = v; w = 3; prev = aa; last = b;
      end
    end
  endtask

  task automatic cmp_mem(string req);
    int bad = 0;
    for (int i = 0; i < 256; i++) if (cmem[i] !== shadow[i]) bad++;
    chk(req, "register map mismatches", bad, 0);
  endtask

  task automatic do_op(string req, int op, bit ind, int a, int idx, int d, int m);
    int wc0, cyc, rsp, w, last, prev;
    wc0 = wr_count;
    send(op, ind, a, idx, d, m);
    wait_done(req, cyc);
    ref_apply(op, ind, a, idx, d, m, rsp, w, last, prev);
    chk(req, "rsp_data", int'(rsp_data), rsp);
    chk(req, "rsp_err", int'(rsp_err), 0);
    chk(req, "write count", wr_count - wc0, w);
    if (w > 0) chk(req, "last write addr", int'(last_wr_addr), last);
    if (w > 1) chk(req, "prior write addr", int'(prev_wr_addr), prev);
    cmp_mem(req);
  endtask

  function automatic string tag_of(int op, bit ind);
    if (!ind) return (op == 0) ? "R2" : (op == 1) ? "R3" : "R4";
    return (op == 0) ? "R6" : (op == 1) ? "R5" : "R7";
  endfunction

  initial begin
    int cyc, wc0, ndone;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 256; i++) shadow[i] = 8'(i * 37 + 5);
    @(negedge clk);
    // R1 reset state
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "done", int'(done), 0);
    chk("R1", "bus_wr", int'(bus_wr), 0);
    chk("R1", "rsp_err", int'(rsp_err), 0);

    do_op("R2", 0, 1'b0, 8'h10, 0, 0, 0);
    ack_dly = 3;
    do_op("R3", 1, 1'b0, 8'h20, 0, 8'hA5, 0);
    chk("R3", "strobe after done", int'(bus_wr), 0);
    ack_dly = 0;
    do_op("R4", 2, 1'b0, 8'h30, 0, 8'h06, 8'h0F);
    do_op("R5", 1, 1'b0, 8'h40, 0, 8'hC0, 0);          // bit 7 of control set
    do_op("R5", 1, 1'b1, 8'h40, 8'h15, 8'h77, 0);
    chk("R5", "control word", int'(cmem[8'h40]), 8'hD5);
    do_op("R6", 0, 1'b1, 8'h40, 8'h2A, 0, 0);
    chk("R6", "control word", int'(cmem[8'h40]), 8'hAA);
    ack_dly = 2;
    do_op("R7", 2, 1'b1, 8'h50, 8'h01, 8'h30, 8'hF0);
    do_op("R8", 1, 1'b1, 8'h60, 8'hFF, 8'h3C, 0);
    chk("R8", "control low bits", int'(cmem[8'h60] & 8'h7F), 8'h7F);
    do_op("R12", 1, 1'b1, 8'hFF, 8'h05, 8'h9E, 0);
    chk("R12", "wrapped data reg", int'(cmem[8'h00]), 8'h9E);

    // R9 reserved code
    wc0 = wr_count;
    send(3, 1'b0, 8'h70, 0, 8'h11, 0);
    chk("R9", "done after one cycle", int'(done), 1);
    chk("R9", "rsp_err", int'(rsp_err), 1);
    chk("R9", "write count", wr_count - wc0, 0);
    cmp_mem("R9");

    // R10 request while busy is dropped
    ack_dly = 3;
    send(1, 1'b0, 8'h70, 0, 8'h12, 0);
    chk("R10", "busy after accept", int'(busy), 1);
    req_op = 2'd1; req_indirect = 1'b0; req_addr = 8'h71; req_data = 8'h99;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done("R10", cyc);
    begin
      int rsp, w, last, prev;
      ref_apply(1, 1'b0, 8'h70, 0, 8'h12, 0, rsp, w, last, prev);
    end
    ndone = 0;
    repeat (6) begin @(negedge clk); if (done) ndone++; end
    chk("R10", "extra done pulses", ndone, 0);
    chk("R10", "dropped write target", int'(cmem[8'h71]), int'(shadow[8'h71]));
    cmp_mem("R10");

    // R11 timeout on direct and on indirect control write
    stall = 1'b1;
    send(1, 1'b0, 8'h80, 0, 8'h11, 0);
    wait_done("R11", cyc);
    chk("R11", "rsp_err direct", int'(rsp_err), 1);
    chk("R11", "done within bound", int'(cyc <= TMO + 6), 1);
    chk("R11", "strobe dropped", int'(bus_wr), 0);
    send(1, 1'b1, 8'h90, 8'h03, 8'h22, 0);
    wait_done("R11", cyc);
    chk("R11", "rsp_err indirect", int'(rsp_err), 1);
    cmp_mem("R11");
    stall = 1'b0;
    do_op("R11", 1, 1'b0, 8'h80, 0, 8'h33, 0);

    // random mix
    for (int n = 0; n < 200; n++) begin
      int op; bit ind;
      op  = int'($urandom_range(0, 2));
      ind = 1'(($urandom() >> 5) & 1);
      ack_dly = $urandom_range(0, 3);
      do_op(tag_of(op, ind), op, ind, int'($urandom_range(0, 255)),
            int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
            int'($urandom_range(0, 255)));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule